// File: doc/BRIEF.md
# Privileged Coprocessor Register Access Unit

This unit sits beside an instruction decoder and services register-transfer instructions aimed at a single coprocessor number. It holds two registers: an execution-environment control register in which only bit 0 has meaning, and a full-width handler base register. Each valid instruction resolves, one cycle later, to exactly one of four outcomes: a completed access, an undefined-instruction trap, a hand-off to an external hook for coprocessors this unit does not own, or nothing when the strobe is low.

Reads return the register value on a writeback port naming the destination general register. Writes take the general-register read data presented with the instruction. A write that flips the control bit raises a one-cycle change pulse. Downstream logic such as a translation cache uses it to flush, and a write that leaves the bit as it was stays silent.

Privilege is checked per register. User code can never touch the control register. User code may reach the handler base register only while the control bit is clear.

Top module: `cpreg_access_unit`

## Requirements
- R1: After reset both registers read as zero and wb_en, undef_trap, hook_fwd and ctl_chg are low.
- R2: Instruction fields: op1 = bits 23:21, CRn = 19:16, CRm = 3:0, op2 = 7:5, coprocessor number = 11:8 (parameter CP_NUM, default 14). The control register is op1=6, CRn=0, CRm=0, op2=0. The handler base register is op1=6, CRn=1, CRm=0, op2=0.
- R3: Bit 20 = 1 is a read. A granted read pulses wb_en one cycle after the strobe, with wb_idx = bits 15:12. For the handler base register wb_data holds all 32 stored bits; for the control register it holds bit 0 zero-extended.
- R4: A granted control-register write stores gpr_rdata bit 0 only, and ctl_chg pulses in the same cycle as the result exactly when the stored bit changes.
- R5: A granted handler-base write (bit 20 = 0) stores all 32 bits of gpr_rdata.
- R6: Any user-mode access to the control register, read or write, traps.
- R7: A user-mode access to the handler base register traps only while the control bit is 1; privileged accesses to either register are granted.
- R8: With feat_en low, or with any other field combination, an instruction for CP_NUM traps.
- R9: With alt_core high, or a coprocessor number other than CP_NUM, hook_fwd pulses and neither a trap nor an access occurs.
- R10: A trapped or forwarded instruction changes neither register and gives no writeback. All outputs pulse for one cycle only after a strobe, and at most one of wb_en, undef_trap, hook_fwd is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction strobe |
| instr_word | input | 32 | Coprocessor register-transfer instruction |
| user_mode | input | 1 | High when executing unprivileged |
| gpr_rdata | input | DATA_W | Source general-register value for writes |
| feat_en | input | 1 | Feature strap enabling the two registers |
| alt_core | input | 1 | Strap sending every instruction to the hook |
| wb_en | output | 1 | Writeback strobe |
| wb_idx | output | 4 | Destination general register |
| wb_data | output | DATA_W | Writeback value |
| undef_trap | output | 1 | Undefined-instruction trap pulse |
| hook_fwd | output | 1 | Hand-off to external coprocessor hook |
| ctl_chg | output | 1 | Control bit changed |

## Verification
On every cycle the assertions check that the three outcomes never overlap, that no pulse appears without a preceding strobe, and that the change pulse matches a real toggle of the control bit in both directions. They also check that a trap leaves both registers untouched, and that user control accesses, straps-off accesses and forwarded instructions take their fixed outcome. Only the bench's scenarios can show the data path. That means the zero-extended control readback, full-width handler base storage, and the correct destination index. They also show the user access to the handler base flipping between granted and trapped as the control bit is set and cleared.

// File: rtl/cpreg_pkg.sv
package cpreg_pkg;
    localparam int INSTR_W = 32;
    localparam int IDX_W   = 4;
    localparam int OP1_LO  = 21;
    localparam int DIR_BIT = 20;
    localparam int CRN_LO  = 16;
    localparam int RT_LO   = 12;
    localparam int CPN_LO  = 8;
    localparam int OP2_LO  = 5;
    localparam int CRM_LO  = 0;
    localparam logic [2:0] SEL_OP1 = 3'd6;
    localparam logic [3:0] CRN_CTL = 4'd0;
    localparam logic [3:0] CRN_HB  = 4'd1;

    typedef struct packed {
        logic             is_read;
        logic [IDX_W-1:0] rt;
        logic             cp_match;
        logic             sel_ctl;
        logic             sel_hb;
    } dec_t;
endpackage

// File: rtl/cpreg_decode.sv
module cpreg_decode
    import cpreg_pkg::*;
#(
    parameter int CP_NUM = 14
) (
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    logic [2:0] op1, op2;
    logic [3:0] crn, crm, cpn;
    logic       base_hit;
    logic       unused_bits;

    assign op1 = instr[OP1_LO +: 3];
    assign op2 = instr[OP2_LO +: 3];
    assign crn = instr[CRN_LO +: 4];
    assign crm = instr[CRM_LO +: 4];
    assign cpn = instr[CPN_LO +: 4];
    assign unused_bits = ^{instr[31:24], instr[4]};

    assign base_hit = (op1 == SEL_OP1) && (crm == 4'd0) && (op2 == 3'd0);

    always_comb begin
        dec.is_read  = instr[DIR_BIT];
        dec.rt       = instr[RT_LO +: IDX_W];
        dec.cp_match = (cpn == 4'(CP_NUM));
        dec.sel_ctl  = base_hit && (crn == CRN_CTL);
        dec.sel_hb   = base_hit && (crn == CRN_HB);
    end
endmodule

// File: rtl/cpreg_perm.sv
module cpreg_perm
    import cpreg_pkg::*;
(
    input  logic valid,
    input  dec_t dec,
    input  logic user,
    input  logic feat_en,
    input  logic alt_core,
    input  logic ctl_bit,
    output logic grant,
    output logic trap,
    output logic fwd
);
    logic local_op, known, denied;

    always_comb begin
        fwd      = valid && (alt_core || !dec.cp_match);
        local_op = valid && !fwd;
        known    = feat_en && (dec.sel_ctl || dec.sel_hb);
        denied   = user && (dec.sel_ctl || (dec.sel_hb && ctl_bit));
        grant    = local_op && known && !denied;
        trap     = local_op && !grant;
    end
endmodule

// File: rtl/cpreg_access_unit.sv
module cpreg_access_unit
    import cpreg_pkg::*;
#(
    parameter int CP_NUM = 14,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [31:0]       instr_word,
    input  logic              user_mode,
    input  logic [DATA_W-1:0] gpr_rdata,
    input  logic              feat_en,
    input  logic              alt_core,
    output logic              wb_en,
    output logic [3:0]        wb_idx,
    output logic [DATA_W-1:0] wb_data,
    output logic              undef_trap,
    output logic              hook_fwd,
    output logic              ctl_chg
);
    typedef struct packed {
        logic              ctl;
        logic [DATA_W-1:0] hbase;
        logic              wb_en;
        logic [IDX_W-1:0]  wb_idx;
        logic [DATA_W-1:0] wb_data;
        logic              trap;
        logic              fwd;
        logic              chg;
    } st_t;

    st_t  st_d, st_q;
    dec_t dec;
    logic grant, trap, fwd;
    logic              ctl_q;
    logic [DATA_W-1:0] hbase_q;

    assign ctl_q   = st_q.ctl;
    assign hbase_q = st_q.hbase;

    cpreg_decode #(.CP_NUM(CP_NUM)) u_dec (
        .instr (instr_word),
        .dec   (dec)
    );

    cpreg_perm u_perm (
        .valid    (instr_valid),
        .dec      (dec),
        .user     (user_mode),
        .feat_en  (feat_en),
        .alt_core (alt_core),
        .ctl_bit  (st_q.ctl),
        .grant    (grant),
        .trap     (trap),
        .fwd      (fwd)
    );

    always_comb begin
        st_d         = st_q;
        st_d.wb_en   = 1'b0;
        st_d.wb_idx  = '0;
        st_d.wb_data = '0;
        st_d.trap    = trap;
        st_d.fwd     = fwd;
        st_d.chg     = 1'b0;
        if (grant) begin
            if (dec.is_read) begin
                st_d.wb_en   = 1'b1;
                st_d.wb_idx  = dec.rt;
                st_d.wb_data = dec.sel_ctl ? {{(DATA_W-1){1'b0}}, st_q.ctl} : st_q.hbase;
            end else if (dec.sel_ctl) begin
                st_d.ctl = gpr_rdata[0];
                st_d.chg = (gpr_rdata[0] != st_q.ctl);
            end else begin
                st_d.hbase = gpr_rdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wb_en      = st_q.wb_en;
    assign wb_idx     = st_q.wb_idx;
    assign wb_data    = st_q.wb_data;
    assign undef_trap = st_q.trap;
    assign hook_fwd   = st_q.fwd;
    assign ctl_chg    = st_q.chg;
endmodule

// File: rtl/cpreg_access_chk.sv
module cpreg_access_chk #(
    parameter int CP_NUM = 14,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic [31:0]       instr_word,
    input logic              user_mode,
    input logic              feat_en,
    input logic              alt_core,
    input logic              wb_en,
    input logic              undef_trap,
    input logic              hook_fwd,
    input logic              ctl_chg,
    input logic              ctl_q,
    input logic [DATA_W-1:0] hbase_q
);
    logic own_cp, ctl_fields;
    assign own_cp     = (instr_word[11:8] == 4'(CP_NUM)) && !alt_core;
    assign ctl_fields = (instr_word[23:21] == 3'd6) && (instr_word[19:16] == 4'd0)
                     && (instr_word[3:0] == 4'd0) && (instr_word[7:5] == 3'd0);

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wb_en, undef_trap, hook_fwd})); // R10
    AST_NO_IDLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> !(wb_en || undef_trap || hook_fwd || ctl_chg)); // R10
    AST_TRAP_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (undef_trap || hook_fwd) |-> (ctl_q == $past(ctl_q)) && (hbase_q == $past(hbase_q))); // R10
    AST_CHG_ON_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_chg |-> (ctl_q != $past(ctl_q))); // R4
    AST_TOGGLE_SIGNALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q != $past(ctl_q)) |-> ctl_chg); // R4
    AST_USER_CTL_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && own_cp && user_mode && ctl_fields) |=> undef_trap); // R6
    AST_STRAP_OFF_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && own_cp && !feat_en) |=> undef_trap); // R8
    AST_FWD_TO_HOOK: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !own_cp) |=> (hook_fwd && !undef_trap)); // R9
endmodule

bind cpreg_access_unit cpreg_access_chk #(.CP_NUM(CP_NUM), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .user_mode   (user_mode),
    .feat_en     (feat_en),
    .alt_core    (alt_core),
    .wb_en       (wb_en),
    .undef_trap  (undef_trap),
    .hook_fwd    (hook_fwd),
    .ctl_chg     (ctl_chg),
    .ctl_q       (ctl_q),
    .hbase_q     (hbase_q)
);

// File: tb/cpreg_access_unit_tb.sv
module cpreg_access_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_valid = 1'b0;
    logic [31:0]   instr_word = '0;
    logic          user_mode = 1'b0;
    logic [DW-1:0] gpr_rdata = '0;
    logic          feat_en = 1'b1;
    logic          alt_core = 1'b0;
    logic          wb_en, undef_trap, hook_fwd, ctl_chg;
    logic [3:0]    wb_idx;
    logic [DW-1:0] wb_data;

    int checks = 0;
    int errors = 0;
    logic          m_ctl = 1'b0;
    logic [DW-1:0] m_hb  = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpreg_access_unit u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .user_mode(user_mode), .gpr_rdata(gpr_rdata), .feat_en(feat_en), .alt_core(alt_core),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .undef_trap(undef_trap),
        .hook_fwd(hook_fwd), .ctl_chg(ctl_chg)
    );

    function automatic logic [31:0] mk(input logic rd, input logic [3:0] cp, input logic [2:0] op1,
                                       input logic [3:0] crn, input logic [3:0] crm,
                                       input logic [2:0] op2, input logic [3:0] rt);
        return {4'hE, 4'hE, op1, rd, crn, rt, cp, op2, 1'b1, crm};
    endfunction

    task automatic chk(input string tag, input logic [DW+7:0] act, input logic [DW+7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drives one instruction, then compares {wb_en,trap,fwd,chg,idx,data} to the model.
    task automatic op(input string tag, input logic [31:0] w, input logic usr, input logic [DW-1:0] g);
        logic is_ctl, is_hb, own, grant, trp, fwd, chg, en;
        logic [DW-1:0] d;
        @(negedge clk);
        instr_word = w; user_mode = usr; gpr_rdata = g; instr_valid = 1'b1;
        own    = !alt_core && (w[11:8] == 4'd14);
        is_ctl = w[23:21] == 3'd6 && w[19:16] == 4'd0 && w[3:0] == 4'd0 && w[7:5] == 3'd0;
        is_hb  = w[23:21] == 3'd6 && w[19:16] == 4'd1 && w[3:0] == 4'd0 && w[7:5] == 3'd0;
        fwd    = !own;
        grant  = own && feat_en && (is_ctl || (is_hb && !(usr && m_ctl)))
                 && !(usr && is_ctl);
        trp    = own && !grant;
        en     = grant && w[20];
        d      = !en ? '0 : (is_ctl ? {{(DW-1){1'b0}}, m_ctl} : m_hb);
        chg    = grant && !w[20] && is_ctl && (g[0] != m_ctl);
        if (grant && !w[20]) begin
            if (is_ctl) m_ctl = g[0];
            else        m_hb  = g;
        end
        @(negedge clk);
        instr_valid = 1'b0;
        chk(tag, {wb_en, undef_trap, hook_fwd, ctl_chg, wb_idx, wb_data},
                 {en, trp, fwd, chg, (en ? w[15:12] : 4'd0), d});
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] w;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {wb_en, undef_trap, hook_fwd, ctl_chg, wb_idx, wb_data}, '0);
        rst_n = 1'b1;
        op("R1 ctl reads zero",   mk(1, 14, 6, 0, 0, 0, 4'd3), 0, 32'hFFFF_FFFF);
        op("R1 hb reads zero",    mk(1, 14, 6, 1, 0, 0, 4'd4), 0, 32'hFFFF_FFFF);
        op("R5 hb write",         mk(0, 14, 6, 1, 0, 0, 4'd0), 0, 32'hDEAD_BEEF);
        op("R3 hb read full",     mk(1, 14, 6, 1, 0, 0, 4'd9), 0, 32'h0);
        op("R4 ctl write masked", mk(0, 14, 6, 0, 0, 0, 4'd1), 0, 32'hFFFF_FFF3);
        op("R4 ctl same no pulse",mk(0, 14, 6, 0, 0, 0, 4'd1), 0, 32'h0000_0005);
        op("R3 ctl read zext",    mk(1, 14, 6, 0, 0, 0, 4'd15), 0, 32'h0);
        op("R7 user hb trap",     mk(1, 14, 6, 1, 0, 0, 4'd2), 1, 32'h0);
        op("R7 user hb wr trap",  mk(0, 14, 6, 1, 0, 0, 4'd2), 1, 32'h1234_5678);
        op("R7 priv hb ok",       mk(1, 14, 6, 1, 0, 0, 4'd2), 0, 32'h0);
        op("R6 user ctl rd trap", mk(1, 14, 6, 0, 0, 0, 4'd2), 1, 32'h0);
        op("R6 user ctl wr trap", mk(0, 14, 6, 0, 0, 0, 4'd2), 1, 32'h0);
        op("R4 ctl clear pulse",  mk(0, 14, 6, 0, 0, 0, 4'd1), 0, 32'h0);
        op("R7 user hb ok",       mk(1, 14, 6, 1, 0, 0, 4'd7), 1, 32'h0);
        op("R8 bad crm",          mk(1, 14, 6, 1, 1, 0, 4'd7), 0, 32'h0);
        op("R8 bad op1",          mk(0, 14, 5, 0, 0, 0, 4'd7), 0, 32'h1);
        op("R2 bad op2",          mk(1, 14, 6, 0, 0, 1, 4'd7), 0, 32'h0);
        feat_en = 1'b0;
        op("R8 strap off",        mk(0, 14, 6, 1, 0, 0, 4'd0), 0, 32'h5555_AAAA);
        feat_en = 1'b1;
        op("R10 hb unchanged",    mk(1, 14, 6, 1, 0, 0, 4'd1), 0, 32'h0);
        op("R9 other cp",         mk(0, 15, 6, 0, 0, 0, 4'd0), 0, 32'h1);
        alt_core = 1'b1;
        op("R9 alt core",         mk(0, 14, 6, 0, 0, 0, 4'd0), 0, 32'h1);
        alt_core = 1'b0;
        op("R10 ctl unchanged",   mk(1, 14, 6, 0, 0, 0, 4'd1), 0, 32'h0);
        for (int i = 0; i < 400; i++) begin
            logic [3:0] crn, cp;
            logic [2:0] op1;
            crn = ($urandom % 3 == 0) ? 4'($urandom) : 4'($urandom % 2);
            op1 = ($urandom % 5 == 0) ? 3'($urandom) : 3'd6;
            cp  = ($urandom % 6 == 0) ? 4'($urandom) : 4'd14;
            feat_en  = ($urandom % 10) != 0;
            alt_core = ($urandom % 15) == 0;
            w = mk(1'($urandom), cp, op1, crn, ($urandom % 8 == 0) ? 4'($urandom) : 4'd0,
                   ($urandom % 8 == 0) ? 3'($urandom) : 3'd0, 4'($urandom));
            op("R2 random", w, 1'($urandom), $urandom);
            if ($urandom % 4 == 0) begin
                @(negedge clk);
                chk("R10 idle", {wb_en, undef_trap, hook_fwd, ctl_chg, 36'd0}, '0);
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule